// File: doc/BRIEF.md
# Microsecond Tick Timer Bank

This block derives a one-microsecond tick from a faster reference clock and uses it to advance a bank of 32-bit timers. A single prescaler serves every timer. It is an 8-bit counter that reloads from 256 minus the ratio of the reference frequency to the tick frequency. With the default 25 MHz reference and 1 MHz tick, the reload value is 231 and one tick occurs every 25 reference clocks.

Each timer holds a counter, a compare value and a control word. While a timer runs, its counter advances on every tick. When the counter equals the compare value on a tick, that is a match. A match can return the counter to zero, adds one to a 4-bit saturating tally, and sets a status flag. The status flag drives the timer's interrupt line through an enable bit. Software reaches the timers over a plain word-addressed register bus with byte enables. Reads return a whole word. A write changes state only when all four byte enables are set.

Top module: `usec_tick_timer`

## Requirements
- R1: The prescaler reloads from 256 minus REF_MHZ/TICK_MHZ (231 by default) and issues one tick every REF_MHZ/TICK_MHZ clocks (25 by default). In any 250 consecutive clocks exactly 10 ticks occur.
- R2: Every timer is driven by the same tick, so two running timers advance by identical amounts over any interval.
- R3: With the run bit (control bit 0) set, the counter adds one on each tick. With it clear, the counter keeps its value.
- R4: The counter can be written at any time. A counter write in the same cycle as a tick wins over the increment.
- R5: With the clear-on-match bit (control bit 1) set, a tick that finds the counter equal to the compare value loads zero instead of counting up.
- R6: With the clear-on-match bit clear, the counter passes the compare value and wraps from 2^32-1 to 0.
- R7: Every match sets the status bit (control bit 4). Writing 1 to bit 4 clears it, but a match in the same cycle keeps it set. Each interrupt line is high exactly when that timer's status bit and interrupt-enable bit (control bit 3) are both set.
- R8: The tally (control bits 11:8, also at register 3 bits 3:0) counts matches and saturates at 15. Writing 1 to control bit 2 zeroes it. Bit 2 always reads 0.
- R9: A write with any byte enable clear leaves every register unchanged.
- R10: Register address is {timer index, select}. Select 0 is control, 1 is compare, 2 is counter and 3 is the read-only tally.
- R11: After reset, every counter, compare and control field reads 0, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Word address: timer index above a 2-bit register select |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; all must be set for a write to act |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | NUM_TIMERS | Per-timer interrupt, status AND enable |

## Verification
The in-line assertions check the following on every cycle:
- each tick is followed by a prescaler reload;
- a stopped counter holds its value;
- a running counter steps by one;
- a clear-on-match tick yields zero;
- a match leaves status set;
- a full tally stays at 15.

Some behaviour depends on phase and programming sequences, and only the bench scenarios can show it:
- that exactly 10 ticks fall in any 250 clocks;
- that two timers stay in lockstep;
- that a counter write landing on a tick edge wins;
- the wrap past 2^32-1;
- the tally count and its clear;
- that partial writes are rejected.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned TALLY_W = 4;

    // control word field positions
    parameter int unsigned CTL_RUN = 0;
    parameter int unsigned CTL_CLRMATCH = 1;
    parameter int unsigned CTL_TALLYCLR = 2;
    parameter int unsigned CTL_IEN = 3;
    parameter int unsigned CTL_STAT = 4;
    parameter int unsigned CTL_TALLY_LO = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_CNT   = 2'd2,
        SEL_TALLY = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0]  cnt;
        logic [DATA_W-1:0]  cmp;
        logic               run;
        logic               clr_on_match;
        logic               ien;
        logic               stat;
        logic [TALLY_W-1:0] tally;
    } timer_state_t;
endpackage

// File: rtl/usec_prescaler.sv
module usec_prescaler #(
    parameter int unsigned REF_MHZ  = 25,
    parameter int unsigned TICK_MHZ = 1,
    parameter int unsigned PRE_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned RATIO = REF_MHZ / TICK_MHZ;
    localparam logic [PRE_W-1:0] RELOAD = PRE_W'((1 << PRE_W) - RATIO);
    localparam logic [PRE_W-1:0] TOP = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == TOP) begin
            st_d.cnt = RELOAD;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= RELOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == TOP);

    assert_reload_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == RELOAD));
endmodule

// File: rtl/usec_timer_chan.sv
module usec_timer_chan
    import usec_tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_cnt,
    output logic [DATA_W-1:0] rd_cmp,
    output logic [DATA_W-1:0] rd_ctrl,
    output logic [DATA_W-1:0] rd_tally,
    output logic              irq
);
    localparam logic [TALLY_W-1:0] TALLY_FULL = {TALLY_W{1'b1}};

    timer_state_t st_d, st_q;
    logic cnt_wr, cmp_wr, ctl_wr, at_cmp, match, tally_clr;

    assign cnt_wr    = wr_en && (wr_sel == SEL_CNT);
    assign cmp_wr    = wr_en && (wr_sel == SEL_CMP);
    assign ctl_wr    = wr_en && (wr_sel == SEL_CTRL);
    assign at_cmp    = (st_q.cnt == st_q.cmp);
    assign match     = tick && st_q.run && at_cmp && !cnt_wr;
    assign tally_clr = ctl_wr && wdata[CTL_TALLYCLR];

    always_comb begin
        st_d = st_q;
        // counter: a software write beats the tick
        if (cnt_wr) begin
            st_d.cnt = wdata;
        end else if (tick && st_q.run) begin
            if (at_cmp && st_q.clr_on_match) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (cmp_wr) begin
            st_d.cmp = wdata;
        end
        if (ctl_wr) begin
            st_d.run          = wdata[CTL_RUN];
            st_d.clr_on_match = wdata[CTL_CLRMATCH];
            st_d.ien          = wdata[CTL_IEN];
        end
        // status: a match in the clearing cycle is kept
        st_d.stat = match || (st_q.stat && !(ctl_wr && wdata[CTL_STAT]));
        // tally: clear first, then count a coincident match
        if (tally_clr) begin
            st_d.tally = match ? TALLY_W'(1) : '0;
        end else if (match && st_q.tally != TALLY_FULL) begin
            st_d.tally = st_q.tally + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_ctrl = '0;
        rd_ctrl[CTL_RUN]      = st_q.run;
        rd_ctrl[CTL_CLRMATCH] = st_q.clr_on_match;
        rd_ctrl[CTL_IEN]      = st_q.ien;
        rd_ctrl[CTL_STAT]     = st_q.stat;
        rd_ctrl[CTL_TALLY_LO +: TALLY_W] = st_q.tally;
    end

    assign rd_cnt   = st_q.cnt;
    assign rd_cmp   = st_q.cmp;
    assign rd_tally = DATA_W'(st_q.tally);
    assign irq      = st_q.stat && st_q.ien;

    assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !cnt_wr) |=> $stable(st_q.cnt));
    assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.run && !at_cmp && !cnt_wr) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    assert_zero_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && st_q.clr_on_match) |=> (st_q.cnt == '0));
    assert_status_after_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> st_q.stat);
    assert_tally_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tally == TALLY_FULL && !tally_clr) |=> (st_q.tally == TALLY_FULL));
endmodule

// File: rtl/usec_tick_timer.sv
module usec_tick_timer
    import usec_tick_pkg::*;
#(
    parameter int unsigned NUM_TIMERS = 2,
    parameter int unsigned REF_MHZ    = 25,
    parameter int unsigned TICK_MHZ   = 1,
    parameter int unsigned PRE_W      = 8,
    parameter int unsigned IDX_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
    parameter int unsigned ADDR_W     = IDX_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [3:0]            bus_be,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);
    logic             tick;
    logic             full_wr;
    logic [IDX_W-1:0] idx;
    logic [1:0]       sel;

    logic [DATA_W-1:0] cnt_v   [NUM_TIMERS];
    logic [DATA_W-1:0] cmp_v   [NUM_TIMERS];
    logic [DATA_W-1:0] ctrl_v  [NUM_TIMERS];
    logic [DATA_W-1:0] tally_v [NUM_TIMERS];

    assign full_wr = bus_wr && (&bus_be);
    assign idx     = bus_addr[ADDR_W-1:2];
    assign sel     = bus_addr[1:0];

    usec_prescaler #(
        .REF_MHZ  (REF_MHZ),
        .TICK_MHZ (TICK_MHZ),
        .PRE_W    (PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
        usec_timer_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_en    (full_wr && (idx == IDX_W'(g))),
            .wr_sel   (sel),
            .wdata    (bus_wdata),
            .rd_cnt   (cnt_v[g]),
            .rd_cmp   (cmp_v[g]),
            .rd_ctrl  (ctrl_v[g]),
            .rd_tally (tally_v[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (idx == IDX_W'(i)) begin
                case (sel)
                    SEL_CTRL: bus_rdata = ctrl_v[i];
                    SEL_CMP:  bus_rdata = cmp_v[i];
                    SEL_CNT:  bus_rdata = cnt_v[i];
                    default:  bus_rdata = tally_v[i];
                endcase
            end
        end
    end
endmodule

// File: tb/usec_tick_timer_tb.sv
module usec_tick_timer_tb;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [1:0]        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    usec_tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // control bits: 0 run, 1 clear-on-match, 2 tally clear, 3 irq enable, 4 status
    localparam logic [31:0] C_RUN = 32'h1, C_CLRM = 32'h2, C_TCLR = 32'h4,
                            C_IEN = 32'h8, C_STAT = 32'h10;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int t, input int s, input logic [31:0] d,
                      input logic [3:0] be = 4'hF);
        bus_addr  = ADDR_W'((t << 2) | s);
        bus_wdata = d;
        bus_be    = be;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_be    = '0;
    endtask

    task automatic rd(input int t, input int s, output logic [31:0] d);
        bus_addr = ADDR_W'((t << 2) | s);
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int t = 0; t < 2; t++) begin
            for (int s = 0; s < 4; s++) begin
                rd(t, s, v);
                check(v == 0, "R11 reset value", v, 0);
            end
        end
        check(irq == 2'b00, "R11 irq low", 32'(irq), 0);
    endtask

    task automatic t_rate_and_share;
        logic [31:0] a, b, a2, b2;
        wr(0, 2, 0);
        wr(0, 0, C_RUN);
        wait_clks(250);
        rd(0, 2, a);
        check(a == 10, "R1 ten ticks in 250 clocks", a, 10);
        wr(1, 0, C_RUN);
        wait_clks(3);
        rd(0, 2, a); rd(1, 2, b);
        wait_clks(500);
        rd(0, 2, a2); rd(1, 2, b2);
        check(a2 - a == 20, "R3 counts per tick", a2 - a, 20);
        check(b2 - b == a2 - a, "R2 shared tick", b2 - b, a2 - a);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        wr(0, 0, 0);
        wr(0, 2, 100);
        wait_clks(100);
        rd(0, 2, v);
        check(v == 100, "R3 stopped counter holds", v, 100);
    endtask

    task automatic t_write_wins;
        logic [31:0] prev, cur;
        wr(0, 0, C_RUN);
        rd(0, 2, prev);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            rd(0, 2, cur);
            if (cur != prev) break;
        end
        wait_clks(24);
        wr(0, 2, 500);
        rd(0, 2, cur);
        check(cur == 500, "R4 write wins over tick", cur, 500);
        wait_clks(25);
        rd(0, 2, cur);
        check(cur == 501, "R4 counting resumes", cur, 501);
    endtask

    task automatic t_clear_on_match;
        logic [31:0] v;
        wr(0, 0, C_TCLR | C_STAT);
        wr(0, 2, 0);
        wr(0, 1, 3);
        wr(0, 0, C_RUN | C_CLRM | C_IEN);
        wait_clks(250);
        rd(0, 2, v);
        check(v == 2, "R5 clear-on-match sequence", v, 2);
        rd(0, 3, v);
        check(v == 2, "R8 tally of two matches", v, 2);
        rd(0, 0, v);
        check(v[4] == 1'b1, "R7 status set", 32'(v[4]), 1);
        check(irq[0] == 1'b1, "R7 irq asserted", 32'(irq[0]), 1);
        wr(0, 0, C_STAT);
        rd(0, 0, v);
        check(v[4] == 1'b0, "R7 status write-one-clear", 32'(v[4]), 0);
        check(irq[0] == 1'b0, "R7 irq drops", 32'(irq[0]), 0);
        check(v[11:8] == 2, "R10 tally in control", 32'(v[11:8]), 2);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(1, 0, 0);
        wr(1, 2, 0);
        wr(1, 1, 2);
        wr(1, 0, C_RUN);
        wait_clks(100);
        rd(1, 0, v);
        check(v[4] == 1'b1 && irq[1] == 1'b0, "R7 masked irq", {v[4], 3'b0, irq[1]}, 32'h10);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(0, 0, 0);
        wr(0, 1, 5);
        wr(0, 2, 32'hFFFF_FFFE);
        wr(0, 0, C_RUN);
        wait_clks(250);
        rd(0, 2, v);
        check(v == 8, "R6 wrap past 2^32-1", v, 8);
    endtask

    task automatic t_tally;
        logic [31:0] v;
        wr(0, 0, C_TCLR);
        wr(0, 1, 0);
        wr(0, 2, 0);
        wr(0, 0, C_RUN | C_CLRM);
        wait_clks(250);
        rd(0, 3, v);
        check(v == 10, "R8 tally counts", v, 10);
        wait_clks(250);
        rd(0, 3, v);
        check(v == 15, "R8 tally saturates", v, 15);
        wr(0, 0, C_TCLR);
        rd(0, 3, v);
        check(v == 0, "R8 tally clear", v, 0);
        rd(0, 0, v);
        check(v[2] == 1'b0, "R8 clear bit reads 0", 32'(v[2]), 0);
    endtask

    task automatic t_partial;
        logic [31:0] v;
        wr(1, 0, 0);
        wr(1, 2, 32'h55);
        wr(1, 2, 32'hAAAA_AAAA, 4'b0111);
        wr(1, 1, 32'h1234, 4'b1000);
        rd(1, 2, v);
        check(v == 32'h55, "R9 partial counter write ignored", v, 32'h55);
        rd(1, 1, v);
        check(v == 2, "R9 partial compare write ignored", v, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        wait_clks(3);
        t_reset();
        rst_n = 1'b1;
        wait_clks(2);
        t_rate_and_share();
        t_hold();
        t_write_wins();
        t_clear_on_match();
        t_mask();
        t_wrap();
        t_tally();
        t_partial();
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule